// File: doc/BRIEF.md
# Repeating Channel-Scan Sequencer for a Successive-Approximation Converter

This block drives an external successive-approximation converter in a repeating scan. Software programs one control/status word over a simple register bus. The word picks a bank of four channels and the highest channel of the group within that bank, enables the interrupt, and sets a run bit. While the run bit is 1 the sequencer converts channels from the lowest one in the group upward. Before each conversion it waits a sampling interval, then issues a one-cycle start pulse to the converter and waits for its done pulse. Each result goes into a data register owned by that channel.

When the last channel of the group has been stored, the sequencer sets an end-of-pass flag. It then starts over from the lowest channel. The run bit is never cleared by hardware. The first conversion after the run bit is set also waits an extra start-delay interval, so it takes longer than the conversions that follow. Clearing the run bit stops the scan at once. A conversion that is in flight at that moment is dropped, and its result is not stored. The flag can be cleared only by a read that returns it as 1, followed by a write of 0 to it.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the control word (address 0) and all eight data registers (addresses 1 to 8) read 0, `irq` is 0 and `convStart` is 0.
- R2: Control word layout: bit 7 is the end flag, bit 6 is the interrupt enable, bit 5 is the run bit, bit 4 is the bank, and bits 1:0 are the highest channel of the group. Other bits read 0. Writing the run bit to 1 from idle makes the first `convStart` appear START_DLY+SAMPLE_LEN+1 clock edges after the write edge, with `convCh` = {bank, 00}.
- R3: Each later conversion starts SAMPLE_LEN edges after the edge that accepted the previous `convDone`. Channels go up by one within the group: `convCh` = {bank, index}.
- R4: The result sampled with `convDone` is stored in the data register of that channel. Channel c (0 to 7, bank bit as the MSB) reads at address c+1 in bits 9:0.
- R5: When the highest channel of the group is stored, the end flag is set to 1 and the next conversion is again channel {bank, 00}. The run bit stays 1.
- R6: `irq` is 1 exactly when both the end flag and the interrupt enable are 1.
- R7: A write of 0 to the end flag clears it only if the most recent control-word access before it was a read that returned the flag as 1. Otherwise the flag stays set. Writing 1 to the flag never sets it.
- R8: After the run bit is written to 0, no further `convStart` is issued. A conversion in flight is abandoned, and its later `convDone` does not change any data register.
- R9: Writes to the bank and highest-channel fields are ignored while the run bit is 1.
- R10: `convStart` lasts one cycle, and there is never a second start before the done of the current conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | 0 = control word, 1..8 = channel data |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational) |
| convStart | output | 1 | One-cycle start request to the converter |
| convCh | output | 3 | Channel for the started conversion |
| convDone | input | 1 | Converter result valid, one cycle |
| convResult | input | 10 | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
Properties check on every cycle that the start pulse is one cycle long, that a cleared run bit sends the FSM to idle and freezes the data registers, and that the group fields hold during a run. They also check that the channel index steps by one or wraps at pass end with the flag set, and that a set flag survives every write not preceded by an arming read. Only the bench scenarios can show the end-to-end timing of the first and later conversions, the full channel order across banks and group sizes, and the stored values seen through the bus. The same holds for the read-then-write clearing sequence and for dropping an in-flight result when the run bit falls mid-conversion.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_SAMPLE,
    ST_FIRE,
    ST_WAIT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rewind;   // channel index back to 0
    logic advance;  // channel index + 1
    logic store;    // capture converter result
    logic passEnd;  // set end flag
  } seqStrobe_t;

  localparam int CSR_FLAG = 7;
  localparam int CSR_IE   = 6;
  localparam int CSR_RUN  = 5;
  localparam int CSR_BANK = 4;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int START_DLY  = 6,
  parameter int SAMPLE_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runBit,
  input  logic       atLast,
  input  logic       convDone,
  output logic       convStart,
  output seqStrobe_t strobe
);
  localparam int MAX_LEN = (START_DLY > SAMPLE_LEN) ? START_DLY : SAMPLE_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seqState_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strobe   = '0;
    case (state)
      ST_IDLE: begin
        if (runBit) begin
          stateNxt      = ST_DELAY;
          cntNxt        = CNT_W'(START_DLY - 1);
          strobe.rewind = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!runBit) stateNxt = ST_IDLE;
        else if (cnt == '0) begin
          stateNxt = ST_SAMPLE;
          cntNxt   = CNT_W'(SAMPLE_LEN - 1);
        end else cntNxt = cnt - 1'b1;
      end
      ST_SAMPLE: begin
        if (!runBit) stateNxt = ST_IDLE;
        else if (cnt == '0) stateNxt = ST_FIRE;
        else cntNxt = cnt - 1'b1;
      end
      ST_FIRE: begin
        stateNxt = runBit ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        if (!runBit) stateNxt = ST_IDLE;
        else if (convDone) begin
          strobe.store = 1'b1;
          if (atLast) begin
            strobe.passEnd = 1'b1;
            strobe.rewind  = 1'b1;
          end else begin
            strobe.advance = 1'b1;
          end
          stateNxt = ST_SAMPLE;
          cntNxt   = CNT_W'(SAMPLE_LEN - 1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign convStart = (state == ST_FIRE) && runBit;

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |=> state == ST_IDLE);
  assert_first_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && runBit) |=> state == ST_DELAY);
endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import adc_scan_pkg::*;
#(
  parameter int CH_IDX_W = 2,
  parameter int RES_W    = 10,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busSel,
  input  logic                           busWr,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWdata,
  output logic [DATA_W-1:0]              busRdata,
  input  seqStrobe_t                     strobe,
  input  logic [RES_W-1:0]               convResult,
  output logic                           runBit,
  output logic                           atLast,
  output logic [CH_IDX_W:0]              convCh,
  output logic                           irq
);
  localparam int NUM_CH = 2 ** (CH_IDX_W + 1);

  logic                          runR, ieR, flagR, bankR, armR;
  logic [CH_IDX_W-1:0]           topR, idxR;
  logic [NUM_CH-1:0][RES_W-1:0]  results;
  logic                          csrWr, csrRd;

  assign csrWr = busSel && busWr && (busAddr == '0);
  assign csrRd = busSel && !busWr && (busAddr == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runR  <= 1'b0;
      ieR   <= 1'b0;
      flagR <= 1'b0;
      bankR <= 1'b0;
      topR  <= '0;
      armR  <= 1'b0;
    end else begin
      if (csrWr) begin
        runR <= busWdata[CSR_RUN];
        ieR  <= busWdata[CSR_IE];
        if (!runR) begin
          bankR <= busWdata[CSR_BANK];
          topR  <= busWdata[CH_IDX_W-1:0];
        end
        armR <= 1'b0;
        if (armR && !busWdata[CSR_FLAG]) flagR <= 1'b0;
      end else if (csrRd && flagR) begin
        armR <= 1'b1;
      end
      if (strobe.passEnd) flagR <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) idxR <= '0;
    else if (strobe.rewind) idxR <= '0;
    else if (strobe.advance) idxR <= idxR + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) results <= '0;
    else if (strobe.store) begin
      for (int i = 0; i < NUM_CH; i++)
        if (convCh == (CH_IDX_W + 1)'(i)) results[i] <= convResult;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == '0) begin
      busRdata[CSR_FLAG]       = flagR;
      busRdata[CSR_IE]         = ieR;
      busRdata[CSR_RUN]        = runR;
      busRdata[CSR_BANK]       = bankR;
      busRdata[CH_IDX_W-1:0]   = topR;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (busAddr == ADDR_W'(i + 1)) busRdata[RES_W-1:0] = results[i];
    end
  end

  assign runBit = runR;
  assign atLast = (idxR == topR);
  assign convCh = {bankR, idxR};
  assign irq    = flagR && ieR;

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagR && !(csrWr && armR && !busWdata[CSR_FLAG])) |=> flagR);
  assert_group_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (runR && csrWr) |=> ($stable(bankR) && $stable(topR)));
  assert_index_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> idxR == CH_IDX_W'($past(idxR) + 1'b1));
  assert_pass_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.passEnd |=> (flagR && idxR == '0));
  assert_results_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    !runR |=> $stable(results));
  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.passEnd && ieR && !csrWr) |=> irq);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_IDX_W   = 2,
  parameter int RES_W      = 10,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int START_DLY  = 6,
  parameter int SAMPLE_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  convStart,
  output logic [CH_IDX_W:0]     convCh,
  input  logic                  convDone,
  input  logic [RES_W-1:0]      convResult,
  output logic                  irq
);
  seqStrobe_t strobe;
  logic       runBit, atLast;

  scan_ctrl #(.START_DLY(START_DLY), .SAMPLE_LEN(SAMPLE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .runBit(runBit), .atLast(atLast),
    .convDone(convDone), .convStart(convStart), .strobe(strobe)
  );

  scan_dp #(.CH_IDX_W(CH_IDX_W), .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe),
    .convResult(convResult), .runBit(runBit), .atLast(atLast),
    .convCh(convCh), .irq(irq)
  );
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int D = 6;
  localparam int S = 4;

  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0, busWr = 0;
  logic [3:0]  busAddr = 0;
  logic [15:0] busWdata = 0;
  logic [15:0] busRdata;
  logic        convStart;
  logic [2:0]  convCh;
  logic        convDone = 0;
  logic [9:0]  convResult = 0;
  logic        irq;

  adc_scan_seq #(.START_DLY(D), .SAMPLE_LEN(S)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .convStart(convStart), .convCh(convCh),
    .convDone(convDone), .convResult(convResult), .irq(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, lastWrCyc = 0, lastDoneCyc = 0, passes = 0;
  int lat = 0, latForce = -1, startsSeen = 0;
  bit pending = 0, expectRun = 0, firstAfterRun = 0, expFlag = 0, finished = 0;
  logic [2:0] pendCh = 0, expNext = 0;
  logic [9:0] pendRes = 0;
  logic [9:0] expMem [8];
  logic       curBank = 0, curIe = 0;
  logic [1:0] curTop = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] csrWord(input bit flag, input bit ie, input bit run,
                                          input bit bank, input logic [1:0] top);
    csrWord = 16'h0;
    csrWord[7] = flag; csrWord[6] = ie; csrWord[5] = run; csrWord[4] = bank;
    csrWord[1:0] = top;
  endfunction

  // converter model with order and timing checks
  always @(negedge clk) begin
    convDone = 0;
    if (pending) begin
      if (lat == 0) begin
        convDone = 1; convResult = pendRes; pending = 0; lastDoneCyc = cyc + 1;
        if (expectRun) begin
          expMem[pendCh] = pendRes;
          if (pendCh[1:0] == curTop) begin
            expFlag = 1; passes++; expNext = {curBank, 2'b00};
          end else expNext = pendCh + 3'd1;
        end
      end else lat--;
    end
    if (convStart) begin
      startsSeen++;
      chk(expectRun, "R8 start after stop", 1, 0);
      chk(!pending, "R10 second start before done", 1, 0);
      chk(convCh == expNext, "R3 channel order", convCh, expNext);
      if (firstAfterRun) begin
        chk(cyc == lastWrCyc + D + S + 1, "R2 first start timing", cyc - lastWrCyc, D + S + 1);
        firstAfterRun = 0;
      end else
        chk(cyc == lastDoneCyc + S, "R3 later start timing", cyc - lastDoneCyc, S);
      pending = 1;
      lat = (latForce >= 0) ? latForce : $urandom_range(0, 3);
      pendCh = convCh;
      pendRes = 10'($urandom);
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1 lastWrCyc = cyc;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic startRun(input bit bank, input logic [1:0] top, input bit ie);
    curBank = bank; curTop = top; curIe = ie;
    expNext = {bank, 2'b00}; firstAfterRun = 1; expectRun = 1;
    busWrite(4'd0, csrWord(1, ie, 1, bank, top));
  endtask

  task automatic stopRun();
    forever begin
      @(posedge clk); #2;
      if (!convStart && !convDone && !(pending && lat == 0)) break;
    end
    @(negedge clk);
    expectRun = 0;
    busSel = 1; busWr = 1; busAddr = 0; busWdata = csrWord(1, curIe, 0, curBank, curTop);
    @(posedge clk); #1 lastWrCyc = cyc;
    @(negedge clk);
    busSel = 0; busWr = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic verifyIdle(input string tag);
    logic [15:0] rd;
    chk(irq == (expFlag && curIe), "R6 irq level", irq, expFlag && curIe);
    for (int c = 0; c < 8; c++) begin
      busRead(4'(c + 1), rd);
      chk(rd == {6'd0, expMem[c]}, "R4 stored result", rd, expMem[c]);
    end
    busRead(4'd0, rd);
    chk(rd == csrWord(expFlag, curIe, 0, curBank, curTop), "R5 control word after stop",
        rd, csrWord(expFlag, curIe, 0, curBank, curTop));
    if (tag.len() == 0) chk(1, "", 0, 0);
  endtask

  task automatic flagClear();
    logic [15:0] rd;
    // write 0 without a prior read: most recent access before is a write
    busWrite(4'd0, csrWord(1, curIe, 0, curBank, curTop));
    busWrite(4'd0, csrWord(0, curIe, 0, curBank, curTop));
    busRead(4'd0, rd);
    chk(rd[7] == expFlag, "R7 write without read keeps flag", rd[7], expFlag);
    busWrite(4'd0, csrWord(0, curIe, 0, curBank, curTop));
    expFlag = 0;
    busRead(4'd0, rd);
    chk(rd[7] == 0, "R7 read then write clears flag", rd[7], 0);
    chk(irq == 0, "R6 irq low after clear", irq, 0);
    busWrite(4'd0, csrWord(1, curIe, 0, curBank, curTop));
    busRead(4'd0, rd);
    chk(rd[7] == 0, "R7 writing 1 does not set flag", rd[7], 0);
  endtask

  task automatic waitPasses(input int n);
    int target;
    target = passes + n;
    while (passes < target) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int startsBefore;
    logic [2:0] abCh;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 8; c++) expMem[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0, "R1 irq at reset", irq, 0);
    chk(convStart == 0, "R1 convStart at reset", convStart, 0);
    for (int a = 0; a < 9; a++) begin
      busRead(4'(a), rd);
      chk(rd == 0, "R1 register at reset", rd, 0);
    end

    // directed: bank 0, channels 0..3, interrupt on
    startRun(0, 2'd3, 1);
    waitPasses(2);
    busRead(4'd0, rd);
    chk(rd[5] == 1, "R5 run bit stays set", rd[5], 1);
    chk(irq == 1, "R6 irq after pass", irq, 1);
    // R9: try to change group while running
    busWrite(4'd0, csrWord(1, 1, 1, 1, 2'd0));
    busRead(4'd0, rd);
    chk((rd & 16'h7F) == (csrWord(0, 1, 1, 0, 2'd3) & 16'h7F), "R9 group frozen while running",
        rd & 16'h7F, csrWord(0, 1, 1, 0, 2'd3) & 16'h7F);
    waitPasses(1);
    stopRun();
    verifyIdle("dir1");
    flagClear();

    // directed: single channel group, bank 1
    startRun(1, 2'd0, 0);
    waitPasses(3);
    stopRun();
    verifyIdle("dir2");
    chk(irq == 0, "R6 irq masked by enable", irq, 0);

    // directed: abandon a conversion in flight (R8)
    latForce = 12;
    startRun(1, 2'd3, 1);
    while (!(pending && lat >= 3)) @(posedge clk);
    abCh = pendCh;
    startsBefore = startsSeen;
    stopRun();
    latForce = -1;
    repeat (40) @(negedge clk);
    chk(startsSeen == startsBefore, "R8 no start after stop", startsSeen, startsBefore);
    busRead(4'(abCh + 1), rd);
    chk(rd == {6'd0, expMem[abCh]}, "R8 abandoned result not stored", rd, expMem[abCh]);
    verifyIdle("dir3");
    flagClear();

    // constrained random scans
    for (int it = 0; it < 10; it++) begin
      bit b, ie;
      logic [1:0] t;
      b = 1'($urandom); ie = 1'($urandom); t = 2'($urandom);
      startRun(b, t, ie);
      waitPasses(1 + $urandom_range(0, 1));
      repeat ($urandom_range(0, 20)) @(negedge clk);
      if ($urandom_range(0, 1) == 1) begin
        busWrite(4'd0, csrWord(1, ie, 1, ~b, ~t));
        busRead(4'd0, rd);
        chk(rd[4] == b && rd[1:0] == t, "R9 random group write ignored", rd[4:0], {b, 2'b0, t});
      end
      stopRun();
      verifyIdle("rand");
      if ($urandom_range(0, 1) == 1) flagClear();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule